// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a synchronous binary up-counter. Its default width is 4 bits, so it counts modulo 16. It can be loaded with a parallel data word on a clock edge. Two count enables gate the counting. The *parallel* enable is meant to be shared by every stage of a chain. The *trickle* enable also qualifies the terminal-count output. Because the trickle enable reaches the terminal count, several stages can be chained into one wider synchronous counter: each stage's terminal count drives the next stage's trickle enable, and all stages share one parallel enable.

The reset style is chosen when the block is elaborated. With `SYNC_CLEAR = 0` an active-low asynchronous clear forces the count to zero at once. With `SYNC_CLEAR = 1` the same active-low input clears the count on the next rising clock edge. Both variants have the same port list.

On each rising edge the modes apply in a fixed order of priority: clear, then load, then count, then hold. The count output changes only on a rising clock edge, with one exception: the asynchronous clear.

Top module: `preset_bin_counter`

## Requirements
- R1: When a count step happens with the count at its all-ones value (15 for the default width), the next count is 0.
- R2: Priority on a rising edge is fixed: clear beats load, load beats counting, and counting beats holding. A load with both count enables high loads `din` and does not increment.
- R3: With `SYNC_CLEAR = 0`, `rst_n` low forces `count` to 0 without waiting for a clock edge. The count then stays 0 while `rst_n` is low, whatever `load_n`, `din` and the enables do.
- R4: With `SYNC_CLEAR = 1`, `rst_n` low leaves `count` unchanged until the next rising edge and clears it to 0 on that edge, even when `load_n` is low.
- R5: With reset inactive, `load_n` low copies `din` into `count` on the next rising edge, whatever the values of `en_par` and `en_trk`.
- R6: With reset inactive and `load_n` high, `count` increments by one on a rising edge only when `en_par` and `en_trk` are both 1. If either of them is 0, `count` holds its value.
- R7: `tc` is combinational. It is 1 exactly when `count` is all ones and `en_trk` is 1, and it does not depend on `en_par`, `load_n` or `din`.
- R8: `count` does not change between rising edges when `din`, `load_n` or the enables change. The asynchronous clear of R3 is the only exception.
- R9: Two 4-bit stages chained (low stage `tc` to high stage `en_trk`, common `en_par`, and `{high,low}` read as one value) count as a single 8-bit synchronous counter. That counter wraps from 255 to 0.
- R10: After a load of the all-ones value, `tc` is 1 in the following cycle whenever `en_trk` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear; asynchronous or synchronous depending on `SYNC_CLEAR` |
| load_n | input | 1 | Active-low parallel load |
| en_par | input | 1 | Parallel count enable |
| en_trk | input | 1 | Trickle count enable; also gates `tc` |
| din | input | WIDTH | Parallel data loaded on a load edge |
| count | output | WIDTH | Current count value |
| tc | output | 1 | Terminal count: count all ones and `en_trk` high |

## Verification
The bench targets the edges of the priority order. A load with both enables high must not also increment. A clear with a load pending must win over the load. The bench lowers the reset in mid-cycle. An asynchronous variant that waited for the clock would still show the old count there. A synchronous variant that cleared at once would show 0 too early. A `tc` decoded from the registered state, rather than from the live trickle enable, would fail when the trickle enable drops between edges. The bench also runs a two-stage chain through several hundred cycles of irregular enables, past the 255 to 0 wrap. A carry that reached the high stage one cycle late, or that ignored the shared parallel enable, would drift away from the 8-bit reference.

// File: rtl/pbc_pkg.sv
`timescale 1ns/1ps
package pbc_pkg;

   // Operating mode decided for the coming rising edge, highest priority first.
   typedef enum logic [1:0] {
      PBC_CLEAR = 2'd0,
      PBC_LOAD  = 2'd1,
      PBC_STEP  = 2'd2,
      PBC_HOLD  = 2'd3
   } pbc_mode_e;

   // Widest counter the library accepts for a single stage.
   localparam int unsigned PBC_MAX_WIDTH = 32;

endpackage

// File: rtl/pbc_mode_sel.sv
`timescale 1ns/1ps
module pbc_mode_sel
   import pbc_pkg::*;
(
   input  logic      clr_req,
   input  logic      load_n,
   input  logic      en_par,
   input  logic      en_trk,
   output pbc_mode_e mode
);

   logic step_ok;

   assign step_ok = en_par & en_trk;

   always_comb begin
      if (clr_req) begin
         mode = PBC_CLEAR;
      end else if (!load_n) begin
         mode = PBC_LOAD;
      end else if (step_ok) begin
         mode = PBC_STEP;
      end else begin
         mode = PBC_HOLD;
      end
   end

endmodule

// File: rtl/pbc_next_val.sv
`timescale 1ns/1ps
module pbc_next_val
   import pbc_pkg::*;
#(
   parameter int unsigned WIDTH = 4
)(
   input  pbc_mode_e        mode,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] nxt
);

   // Per-bit toggle enables: a bit flips when every lower bit is one.
   logic [WIDTH-1:0] carry;
   logic [WIDTH-1:0] inc;

   assign carry[0] = 1'b1;

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign inc[b] = cur[b] ^ carry[b];
      if (b < WIDTH - 1) begin : g_carry
         assign carry[b+1] = carry[b] & cur[b];
      end
   end

   always_comb begin
      unique case (mode)
         PBC_CLEAR: nxt = '0;
         PBC_LOAD:  nxt = din;
         PBC_STEP:  nxt = inc;
         default:   nxt = cur;
      endcase
   end

endmodule

// File: rtl/pbc_state_reg.sv
`timescale 1ns/1ps
module pbc_state_reg #(
   parameter int unsigned WIDTH      = 4,
   parameter bit          SYNC_CLEAR = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] nxt,
   output logic [WIDTH-1:0] q
);

   if (SYNC_CLEAR) begin : g_sync
      // Clear reaches the register through the mode decode as a next value.
      always_ff @(posedge clk) begin
         q <= nxt;
      end
   end else begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else begin
            q <= nxt;
         end
      end
   end

endmodule

// File: rtl/pbc_tc_decode.sv
`timescale 1ns/1ps
module pbc_tc_decode #(
   parameter int unsigned WIDTH = 4
)(
   input  logic [WIDTH-1:0] q,
   input  logic             en_trk,
   output logic             tc
);

   logic at_top;

   assign at_top = &q;
   assign tc     = at_top & en_trk;

endmodule

// File: rtl/preset_bin_counter.sv
`timescale 1ns/1ps
module preset_bin_counter
   import pbc_pkg::*;
#(
   parameter int unsigned WIDTH      = 4,
   parameter bit          SYNC_CLEAR = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_n,
   input  logic             en_par,
   input  logic             en_trk,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] count,
   output logic             tc
);

   if (WIDTH < 1 || WIDTH > PBC_MAX_WIDTH) begin : g_bad_width
      $error("preset_bin_counter: WIDTH %0d outside 1..%0d", WIDTH, PBC_MAX_WIDTH);
   end

   logic             clr_req;
   pbc_mode_e        mode;
   logic [WIDTH-1:0] nxt;
   logic [WIDTH-1:0] q;

   if (SYNC_CLEAR) begin : g_clr_sync
      assign clr_req = ~rst_n;
   end else begin : g_clr_async
      assign clr_req = 1'b0;
   end

   pbc_mode_sel u_mode (
      .clr_req (clr_req),
      .load_n  (load_n),
      .en_par  (en_par),
      .en_trk  (en_trk),
      .mode    (mode)
   );

   pbc_next_val #(.WIDTH(WIDTH)) u_next (
      .mode (mode),
      .cur  (q),
      .din  (din),
      .nxt  (nxt)
   );

   pbc_state_reg #(.WIDTH(WIDTH), .SYNC_CLEAR(SYNC_CLEAR)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .nxt   (nxt),
      .q     (q)
   );

   pbc_tc_decode #(.WIDTH(WIDTH)) u_tc (
      .q      (q),
      .en_trk (en_trk),
      .tc     (tc)
   );

   assign count = q;

endmodule

// File: rtl/pbc_checker.sv
`timescale 1ns/1ps
module pbc_checker #(
   parameter int unsigned WIDTH      = 4,
   parameter bit          SYNC_CLEAR = 1'b0
)(
   input logic             clk,
   input logic             rst_n,
   input logic             load_n,
   input logic             en_par,
   input logic             en_trk,
   input logic [WIDTH-1:0] din,
   input logic [WIDTH-1:0] count,
   input logic             tc
);

   logic seen = 1'b0;

   always_ff @(posedge clk) begin
      seen <= 1'b1;
   end

   p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && en_par && en_trk && count == '1) |=> count == '0);

   p_load_over_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n && en_par && en_trk) |=> count == $past(din));

   if (SYNC_CLEAR) begin : g_sync_chk
      p_sync_clear_r4: assert property (@(posedge clk) disable iff (!seen)
         !rst_n |=> count == '0);
   end else begin : g_async_chk
      p_async_clear_r3: assert property (@(posedge clk)
         !rst_n |-> (count == '0 && !tc));
   end

   p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !load_n |=> count == $past(din));

   p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && en_par && en_trk) |=> count == WIDTH'($past(count) + 1'b1));

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !(en_par && en_trk)) |=> $stable(count));

   p_tc_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en_trk |-> !tc);

   p_tc_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      count != '1 |-> !tc);

   p_tc_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '1 && en_trk) |-> tc);

   p_tc_after_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n && din == '1) |=> (!en_trk || tc));

endmodule

bind preset_bin_counter pbc_checker #(.WIDTH(WIDTH), .SYNC_CLEAR(SYNC_CLEAR)) u_chk (.*);

// File: tb/preset_bin_counter_bench.sv
`timescale 1ns/1ps
module preset_bin_counter_bench;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   int n_checks = 0;
   int n_errors = 0;

   // Chain: low stage is the main instance, high stage fed by its tc.
   logic       rst_n     = 1'b0;
   logic       lo_load_n = 1'b1;
   logic       chain_en  = 1'b0;
   logic       chain_trk = 1'b0;
   logic [3:0] lo_din    = 4'd0;
   logic [3:0] lo_q, hi_q;
   logic       lo_tc, hi_tc;

   // Stand-alone synchronous-clear instance.
   logic       s_rst_n  = 1'b0;
   logic       s_load_n = 1'b1;
   logic       s_en_par = 1'b0;
   logic       s_en_trk = 1'b0;
   logic [3:0] s_din    = 4'd0;
   logic [3:0] s_q;
   logic       s_tc;

   preset_bin_counter #(.WIDTH(4), .SYNC_CLEAR(1'b0)) u_preset_bin_counter (
      .clk(clk), .rst_n(rst_n), .load_n(lo_load_n), .en_par(chain_en),
      .en_trk(chain_trk), .din(lo_din), .count(lo_q), .tc(lo_tc));

   preset_bin_counter #(.WIDTH(4), .SYNC_CLEAR(1'b0)) u_stage_hi (
      .clk(clk), .rst_n(rst_n), .load_n(1'b1), .en_par(chain_en),
      .en_trk(lo_tc), .din(4'd0), .count(hi_q), .tc(hi_tc));

   preset_bin_counter #(.WIDTH(4), .SYNC_CLEAR(1'b1)) u_sync_cnt (
      .clk(clk), .rst_n(s_rst_n), .load_n(s_load_n), .en_par(s_en_par),
      .en_trk(s_en_trk), .din(s_din), .count(s_q), .tc(s_tc));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // One rising edge, then settle 1 ns after it.
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset_state();
      step(); step();
      check(lo_q == 4'd0, "R3 reset count", int'(lo_q), 0);
      check(lo_tc == 1'b0, "R3 reset tc", int'(lo_tc), 0);
      check(hi_q == 4'd0, "R3 reset high stage", int'(hi_q), 0);
      rst_n = 1'b1;
      step();
   endtask

   task automatic t_load();
      lo_din = 4'hA; lo_load_n = 1'b0; chain_en = 1'b0; chain_trk = 1'b0;
      #1;
      check(lo_q == 4'd0, "R8 no change before edge", int'(lo_q), 0);
      step();
      check(lo_q == 4'hA, "R5 load with enables low", int'(lo_q), 10);
      lo_din = 4'd3; chain_en = 1'b1; chain_trk = 1'b1;
      step();
      check(lo_q == 4'd3, "R2 load beats count", int'(lo_q), 3);
      lo_load_n = 1'b1; lo_din = 4'd9;
      #1;
      check(lo_q == 4'd3, "R8 din change between edges", int'(lo_q), 3);
   endtask

   task automatic t_count();
      chain_en = 1'b1; chain_trk = 1'b1; lo_load_n = 1'b1;
      for (int k = 4; k <= 6; k++) begin
         step();
         check(lo_q == 4'(k), "R6 count step", int'(lo_q), k);
      end
      chain_en = 1'b0;
      step();
      check(lo_q == 4'd6, "R6 hold on en_par low", int'(lo_q), 6);
      chain_en = 1'b1; chain_trk = 1'b0;
      step();
      check(lo_q == 4'd6, "R6 hold on en_trk low", int'(lo_q), 6);
   endtask

   task automatic t_tc_wrap();
      lo_din = 4'd14; lo_load_n = 1'b0; chain_en = 1'b0; chain_trk = 1'b1;
      step();
      check(lo_tc == 1'b0, "R7 tc low at 14", int'(lo_tc), 0);
      lo_din = 4'd15;
      step();
      check(lo_q == 4'd15, "R10 loaded 15", int'(lo_q), 15);
      check(lo_tc == 1'b1, "R10 tc after load of 15", int'(lo_tc), 1);
      chain_trk = 1'b0;
      #1;
      check(lo_tc == 1'b0, "R7 tc follows en_trk low", int'(lo_tc), 0);
      chain_trk = 1'b1; chain_en = 1'b0; lo_load_n = 1'b0; lo_din = 4'd2;
      #1;
      check(lo_tc == 1'b1, "R7 tc ignores en_par and load_n", int'(lo_tc), 1);
      lo_load_n = 1'b1; chain_en = 1'b1;
      step();
      check(lo_q == 4'd0, "R1 wrap 15 to 0", int'(lo_q), 0);
      check(lo_tc == 1'b0, "R7 tc low after wrap", int'(lo_tc), 0);
   endtask

   task automatic t_async_clear();
      chain_en = 1'b1; chain_trk = 1'b1;
      step(); step();
      check(lo_q == 4'd2, "R6 count before clear", int'(lo_q), 2);
      rst_n = 1'b0;
      #1;
      check(lo_q == 4'd0, "R3 clear without edge", int'(lo_q), 0);
      lo_load_n = 1'b0; lo_din = 4'd7;
      step();
      check(lo_q == 4'd0, "R3 clear beats load", int'(lo_q), 0);
      rst_n = 1'b1; lo_load_n = 1'b1;
      step();
   endtask

   task automatic t_sync_clear();
      s_rst_n = 1'b1; s_en_par = 1'b1; s_en_trk = 1'b1;
      for (int k = 0; k < 5; k++) step();
      check(s_q == 4'd5, "R6 sync variant counts", int'(s_q), 5);
      s_rst_n = 1'b0; s_load_n = 1'b0; s_din = 4'd9;
      #1;
      check(s_q == 4'd5, "R4 no clear before edge", int'(s_q), 5);
      step();
      check(s_q == 4'd0, "R4 clear on edge beats load", int'(s_q), 0);
      s_load_n = 1'b1;
      step();
      check(s_q == 4'd0, "R4 stays clear", int'(s_q), 0);
      s_rst_n = 1'b1;
      step();
      check(s_q == 4'd1, "R4 counts after release", int'(s_q), 1);
   endtask

   task automatic t_chain();
      logic [7:0] ref_val;
      chain_en = 1'b0; chain_trk = 1'b0; lo_load_n = 1'b1;
      rst_n = 1'b0;
      step();
      rst_n = 1'b1;
      ref_val = 8'd0;
      check({hi_q, lo_q} == ref_val, "R9 chain start", int'({hi_q, lo_q}), 0);
      for (int i = 0; i < 400; i++) begin
         chain_en  = (i % 7) != 3;
         chain_trk = (i % 11) != 5;
         step();
         if (chain_en && chain_trk) ref_val = ref_val + 8'd1;
         check({hi_q, lo_q} == ref_val, "R9 chained count", int'({hi_q, lo_q}), int'(ref_val));
      end
   endtask

   initial begin
      t_reset_state();
      t_load();
      t_count();
      t_tc_wrap();
      t_async_clear();
      t_sync_clear();
      t_chain();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule